// File: doc/BRIEF.md
# Single-Word Command Mailbox

This block carries command words from one producer to one consumer through one shared 32-bit register, with no separate lock. The low 19 bits carry the command payload: a 3-bit control field in bits 18:16 above a 16-bit data field in bits 15:0. One spare upper bit, the handshake bit, records whether the word still waits to be taken. The rest of the upper bits are stored as written. A producer writes the word through a write strobe and can read the live word back at any time. A consumer engine inside the block checks the word whenever its poll strobe is high. When it takes a word, it presents the 19-bit payload with a one-cycle valid pulse.

A build-time parameter picks one of two handshake schemes. In sequence mode, the producer flips the handshake bit for each new word. The consumer accepts a word only when that bit differs from the bit of the last word it took. In flag mode, the producer may write only while the bit is clear, and the stored word always has the bit set. When the consumer takes the word, it clears the bit and leaves every other bit unchanged. A refused write is reported on a busy output. If the producer writes and the consumer takes a word in the same cycle, the consumer's clear is applied first, so the producer's write is accepted.

Top module: `word_mailbox`

## Requirements
- R1: While reset is held and after it is released, the shared word reads 0x00000000, the valid pulse is low and busy is low.
- R2: The payload is bits 18:0 of the shared word. The handshake bit is bit 31. The delivered payload equals bits 18:0 of the word the consumer took, as that word stood in the polling cycle.
- R3: In sequence mode, a poll while bit 31 differs from the bit of the last accepted word raises valid for the following cycle, with that word's payload. After reset, the reference bit is 0.
- R4: In sequence mode, a poll while bit 31 equals the reference bit gives no valid pulse and leaves the word unchanged.
- R5: In flag mode, an accepted producer write stores bits 30:0 as written and sets bit 31, whatever value was written to bit 31.
- R6: In flag mode, a producer write while bit 31 is set is refused. Busy is high in that same cycle and the word does not change.
- R7: In flag mode, a poll while bit 31 is set clears bit 31 by the next cycle, keeps bits 30:0, and gives a valid pulse with the payload.
- R8: In flag mode, a poll while bit 31 is clear gives no valid pulse and leaves the word unchanged.
- R9: In flag mode, when a poll that takes a word and a producer write fall in the same cycle, the clear is applied first. The write is accepted with bit 31 set, busy stays low, and the consumer delivers the payload of the previous word.
- R10: In sequence mode, every producer write is accepted. Busy never rises, and a later write replaces a word that was not yet taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prod_wr | input | 1 | Producer write strobe |
| prod_wdata | input | 32 | Word offered by the producer |
| prod_busy | output | 1 | Producer write refused this cycle (flag mode) |
| mbox_word | output | 32 | Live content of the shared word |
| cons_poll | input | 1 | Consumer poll strobe |
| cons_valid | output | 1 | One-cycle pulse: a payload was taken |
| cons_payload | output | 19 | Payload of the last word taken |

## Verification
The embedded assertions check the following on every cycle:
- a refused write leaves the word untouched;
- in flag mode, the handshake bit rises only after a producer write and falls only after a consumer take;
- every valid pulse follows a poll and carries the payload present in the polling cycle.

Only the bench scenarios can show the rest:
- the same-cycle ordering of clear and write;
- that bit 31 is forced on a write while the upper bits pass through;
- that an unchanged sequence bit is rejected after a long history;
- that an untaken word in sequence mode is replaced.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic {
      MBX_SEQ  = 1'b0,
      MBX_FLAG = 1'b1
   } mbx_mode_e;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
   parameter int                  WORD_W = 32,
   parameter int                  HS_POS = 31,
   parameter mbx_pkg::mbx_mode_e  MODE   = mbx_pkg::MBX_FLAG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              clr_i,
   output logic [WORD_W-1:0] word_o,
   output logic              busy_o
);
   localparam logic [WORD_W-1:0] HS_MASK = {{(WORD_W-1){1'b0}}, 1'b1} << HS_POS;

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_d;

   generate
      if (MODE == mbx_pkg::MBX_FLAG) begin : g_flag
         logic held;
         // the consumer's clear is applied before the producer's check
         always_comb begin
            held = word_q[HS_POS] & ~clr_i;
            busy_o = wr_i & held;
            if (wr_i && !held)
               word_d = wdata_i | HS_MASK;
            else if (clr_i)
               word_d = word_q & ~HS_MASK;
            else
               word_d = word_q;
         end

         // R5
         hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(word_q[HS_POS]) |-> $past(wr_i));
         // R7
         hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(word_q[HS_POS]) |-> $past(clr_i));
      end else begin : g_seq
         always_comb begin
            busy_o = 1'b0;
            word_d = wr_i ? wdata_i : word_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign word_o = word_q;

   // R6
   refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(word_q));
endmodule

// File: rtl/mbx_consumer.sv
module mbx_consumer #(
   parameter int                  PAY_W = 19,
   parameter mbx_pkg::mbx_mode_e  MODE  = mbx_pkg::MBX_FLAG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll_i,
   input  logic             hs_i,
   input  logic [PAY_W-1:0] pay_i,
   output logic             clr_o,
   output logic             valid_o,
   output logic [PAY_W-1:0] payload_o
);
   logic take;

   generate
      if (MODE == mbx_pkg::MBX_FLAG) begin : g_flag
         assign take  = poll_i & hs_i;
         assign clr_o = take;
      end else begin : g_seq
         logic last_q;
         assign take  = poll_i & (hs_i ^ last_q);
         assign clr_o = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    last_q <= 1'b0;
            else if (take) last_q <= hs_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         payload_o <= '0;
      end else begin
         valid_o <= take;
         if (take) payload_o <= pay_i;
      end
   end

   // R3
   valid_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(poll_i));
   // R2
   payload_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> payload_o == $past(pay_i));
endmodule

// File: rtl/word_mailbox.sv
module word_mailbox #(
   parameter int                  WORD_W = 32,
   parameter int                  CTL_W  = 3,
   parameter int                  DAT_W  = 16,
   parameter int                  HS_POS = 31,
   parameter mbx_pkg::mbx_mode_e  MODE   = mbx_pkg::MBX_FLAG
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   prod_wr,
   input  logic [WORD_W-1:0]      prod_wdata,
   output logic                   prod_busy,
   output logic [WORD_W-1:0]      mbox_word,
   input  logic                   cons_poll,
   output logic                   cons_valid,
   output logic [CTL_W+DAT_W-1:0] cons_payload
);
   localparam int PAY_W = CTL_W + DAT_W;

   generate
      if (PAY_W >= WORD_W) begin : g_bad_width
         $error("payload must leave spare bits in the word");
      end
      if (HS_POS < PAY_W || HS_POS >= WORD_W) begin : g_bad_hs
         $error("handshake bit must sit above the payload inside the word");
      end
   endgenerate

   logic clr;

   mbx_store #(.WORD_W(WORD_W), .HS_POS(HS_POS), .MODE(MODE)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (prod_wr),
      .wdata_i (prod_wdata),
      .clr_i   (clr),
      .word_o  (mbox_word),
      .busy_o  (prod_busy)
   );

   mbx_consumer #(.PAY_W(PAY_W), .MODE(MODE)) u_cons (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_i    (cons_poll),
      .hs_i      (mbox_word[HS_POS]),
      .pay_i     (mbox_word[PAY_W-1:0]),
      .clr_o     (clr),
      .valid_o   (cons_valid),
      .payload_o (cons_payload)
   );
endmodule

// File: tb/word_mailbox_bench.sv
module word_mailbox_bench;
   typedef struct packed {
      logic        wr;
      logic [31:0] wd;
      logic        poll;
      logic        busy;
      logic [31:0] word;
      logic        valid;
      logic [18:0] pay;
   } row_t;

   localparam int NROW = 9;
   localparam row_t TBL [NROW] = '{
      '{1'b1, 32'h0001_2345, 1'b0, 1'b0, 32'h8001_2345, 1'b0, 19'h00000},
      '{1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1, 32'h8001_2345, 1'b0, 19'h00000},
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0001_2345, 1'b1, 19'h12345},
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0001_2345, 1'b0, 19'h00000},
      '{1'b1, 32'h8006_0ABC, 1'b0, 1'b0, 32'h8006_0ABC, 1'b0, 19'h00000},
      '{1'b1, 32'h0000_1111, 1'b1, 1'b0, 32'h8000_1111, 1'b1, 19'h60ABC},
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_1111, 1'b1, 19'h01111},
      '{1'b1, 32'h7FFA_5A5A, 1'b0, 1'b0, 32'hFFFA_5A5A, 1'b0, 19'h00000},
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h7FFA_5A5A, 1'b1, 19'h25A5A}
   };
   localparam string TAG [NROW] = '{"R5", "R6", "R7", "R8", "R5", "R9", "R7", "R5", "R2"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        f_wr = 1'b0, f_poll = 1'b0, f_busy, f_valid;
   logic [31:0] f_wd = '0, f_word;
   logic [18:0] f_pay;
   logic        s_wr = 1'b0, s_poll = 1'b0, s_busy, s_valid;
   logic [31:0] s_wd = '0, s_word;
   logic [18:0] s_pay;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   word_mailbox #(.MODE(mbx_pkg::MBX_FLAG)) u_word_mailbox (
      .clk(clk), .rst_n(rst_n), .prod_wr(f_wr), .prod_wdata(f_wd),
      .prod_busy(f_busy), .mbox_word(f_word), .cons_poll(f_poll),
      .cons_valid(f_valid), .cons_payload(f_pay));

   word_mailbox #(.MODE(mbx_pkg::MBX_SEQ)) u_word_mailbox_seq (
      .clk(clk), .rst_n(rst_n), .prod_wr(s_wr), .prod_wdata(s_wd),
      .prod_busy(s_busy), .mbox_word(s_word), .cons_poll(s_poll),
      .cons_valid(s_valid), .cons_payload(s_pay));

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive one cycle of the sequence-mode instance; busy sampled before the edge
   task automatic seq_cyc(input logic wr, input logic [31:0] wd, input logic poll,
                          input string tag, input logic ev, input logic [18:0] ep, input logic [31:0] ew);
      s_wr = wr; s_wd = wd; s_poll = poll;
      #1;
      chk(tag, "seq busy", {31'd0, s_busy}, 32'd0);
      @(negedge clk);
      s_wr = 1'b0; s_poll = 1'b0;
      chk(tag, "seq valid", {31'd0, s_valid}, {31'd0, ev});
      if (ev) chk(tag, "seq payload", {13'd0, s_pay}, {13'd0, ep});
      chk(tag, "seq word", s_word, ew);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1", "flag word in reset", f_word, 32'd0);
      chk("R1", "seq word in reset", s_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "flag valid", {31'd0, f_valid}, 32'd0);
      chk("R1", "flag busy", {31'd0, f_busy}, 32'd0);
      chk("R1", "seq valid", {31'd0, s_valid}, 32'd0);

      // flag-mode vector table
      for (int i = 0; i < NROW; i++) begin
         f_wr = TBL[i].wr; f_wd = TBL[i].wd; f_poll = TBL[i].poll;
         #1;
         chk(TAG[i], "flag busy", {31'd0, f_busy}, {31'd0, TBL[i].busy});
         @(negedge clk);
         f_wr = 1'b0; f_poll = 1'b0;
         chk(TAG[i], "flag word", f_word, TBL[i].word);
         chk(TAG[i], "flag valid", {31'd0, f_valid}, {31'd0, TBL[i].valid});
         if (TBL[i].valid) chk(TAG[i], "flag payload", {13'd0, f_pay}, {13'd0, TBL[i].pay});
      end

      // sequence-mode directed cases
      seq_cyc(1'b0, 32'h0, 1'b1, "R4", 1'b0, 19'h0, 32'h0000_0000);
      seq_cyc(1'b1, 32'h8000_00FF, 1'b0, "R10", 1'b0, 19'h0, 32'h8000_00FF);
      seq_cyc(1'b0, 32'h0, 1'b1, "R3", 1'b1, 19'h000FF, 32'h8000_00FF);
      seq_cyc(1'b0, 32'h0, 1'b1, "R4", 1'b0, 19'h0, 32'h8000_00FF);
      seq_cyc(1'b1, 32'h8000_0001, 1'b0, "R10", 1'b0, 19'h0, 32'h8000_0001);
      seq_cyc(1'b0, 32'h0, 1'b1, "R4", 1'b0, 19'h0, 32'h8000_0001);
      seq_cyc(1'b1, 32'h0007_FFFF, 1'b0, "R10", 1'b0, 19'h0, 32'h0007_FFFF);
      seq_cyc(1'b0, 32'h0, 1'b1, "R3", 1'b1, 19'h7FFFF, 32'h0007_FFFF);
      seq_cyc(1'b1, 32'h8000_0002, 1'b0, "R10", 1'b0, 19'h0, 32'h8000_0002);
      seq_cyc(1'b1, 32'h8000_0003, 1'b0, "R10", 1'b0, 19'h0, 32'h8000_0003);
      seq_cyc(1'b0, 32'h0, 1'b1, "R2", 1'b1, 19'h00003, 32'h8000_0003);

      // R1: reset mid-run returns both instances to zero
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "flag word after reset", f_word, 32'd0);
      chk("R1", "seq word after reset", s_word, 32'd0);
      chk("R1", "seq valid after reset", {31'd0, s_valid}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule